// File: doc/BRIEF.md
# Sequential Restoring Mantissa Divider

This unit divides one normalized floating-point operand by another after special values (zero, infinity, NaN) have already been screened out upstream. Each operand arrives unpacked as a sign, a signed unbiased exponent and a mantissa whose top bit is the hidden 1. The low bits of the mantissa carry the guard and round positions. The unit returns an unrounded quotient mantissa, the result exponent, the result sign and a sticky flag, ready for a separate rounding stage.

A request is presented with a one-cycle `start` while the unit is idle. On the next clock the unit compares the two mantissas and decides the normalization. When the dividend mantissa is the smaller of the two, the exponent is lowered by one and the dividend is doubled, so the quotient always leaves with its top bit set and needs no shift afterwards. The remaining quotient bits are then produced one per clock, most significant first. Each bit comes from a shift, a subtraction of the divisor, and a test of the sign of the difference. The sticky flag is the OR of the remainder that is left at the end.

Top module: `iter_mant_divider`

## Requirements
- R1: After reset, `busy`, `done`, `q_sign`, `q_exp`, `q_mant` and `q_sticky` are all 0.
- R2: A `start` that arrives while `busy` is 1 is ignored. The result of the division in progress, and the cycle in which its `done` appears, are unchanged.
- R3: `done` is high for exactly one cycle. It appears MW clock edges after the edge that accepted `start`. `busy` is 1 from the accept edge until the edge that raises `done`, and it is 0 while `done` is high.
- R4: Take the mantissas as integers X and Y, each with bit MW-1 set. If X >= Y, `q_mant` = floor(X·2^(MW-1)/Y). If X < Y, `q_mant` = floor(X·2^MW/Y). In both cases bit MW-1 of `q_mant` is 1.
- R5: `q_exp` is the signed (EW+1)-bit value ea − eb when X >= Y, and ea − eb − 1 when X < Y. The extreme input exponents must not wrap: the most negative ea with the most positive eb and X < Y gives −2^EW.
- R6: `q_sign` is the XOR of `a_sign` and `b_sign`.
- R7: `q_sticky` is 1 exactly when the division in R4 leaves a nonzero remainder.
- R8: Once `done` has been given, the result outputs keep their values until the next accepted division finishes.
- R9: Equal mantissas give `q_mant` = 2^(MW-1) (1.0), `q_sticky` = 0 and `q_exp` = ea − eb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; accepted only while idle |
| a_sign | input | 1 | Dividend sign |
| a_exp | input | EW | Dividend exponent, signed two's complement |
| a_mant | input | MW | Dividend mantissa, bit MW-1 is the hidden 1 |
| b_sign | input | 1 | Divisor sign |
| b_exp | input | EW | Divisor exponent, signed two's complement |
| b_mant | input | MW | Divisor mantissa, bit MW-1 is the hidden 1 |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: the result outputs are valid |
| q_sign | output | 1 | Quotient sign |
| q_exp | output | EW+1 | Quotient exponent, signed, normalization applied |
| q_mant | output | MW | Quotient mantissa, unrounded, top bit set |
| q_sticky | output | 1 | Nonzero final remainder |

## Verification
A remainder that escapes its bound, or a quotient bit written to the wrong position, shows up as a wrong `q_mant` or `q_sticky` in the same `done` cycle. The bench compares both against a wide integer divide of the operands. A wrong normalization decision changes `q_exp` by one and halves or doubles the quotient, so random operand pairs on both sides of X = Y are mixed with the directed one-ulp neighbours of equality. A counter slip in control moves `done` off cycle MW, and the bench measures this on every operation. A `start` that is wrongly accepted while busy corrupts the operand registers, so the result of a run that was poked mid-flight no longer matches.

// File: rtl/div_pkg.sv
package div_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_ITER  = 2'd2
   } div_phase_e;
endpackage

// File: rtl/div_step.sv
// One restoring step: optional doubling of the partial remainder, trial
// subtraction of the divisor, and keep-or-restore on the sign of the result.
module div_step #(
   parameter int MW = 64
) (
   input  logic [MW:0]   rem_in,
   input  logic [MW-1:0] divisor,
   input  logic          pre_shift,
   output logic          q_bit,
   output logic [MW:0]   rem_out
);
   localparam int DW = MW + 2;

   logic [DW-1:0] lhs;
   logic [DW-1:0] trial;

   always_comb begin
      lhs     = pre_shift ? {rem_in, 1'b0} : {1'b0, rem_in};
      trial   = lhs - {2'b00, divisor};
      q_bit   = ~trial[DW-1];
      rem_out = q_bit ? trial[MW:0] : lhs[MW:0];
   end
endmodule

// File: rtl/div_expo.sv
// Exponent difference widened by one bit, and the sign of the quotient.
module div_expo #(
   parameter int EW = 11
) (
   input  logic signed [EW-1:0] ea,
   input  logic signed [EW-1:0] eb,
   input  logic                 sa,
   input  logic                 sb,
   output logic signed [EW:0]   ediff,
   output logic                 sign
);
   logic signed [EW:0] ea_w;
   logic signed [EW:0] eb_w;

   always_comb begin
      ea_w  = {ea[EW-1], ea};
      eb_w  = {eb[EW-1], eb};
      ediff = ea_w - eb_w;
      sign  = sa ^ sb;
   end
endmodule

// File: rtl/div_ctrl.sv
// Sequencer: idle -> setup (one cycle) -> MW-1 iteration cycles -> idle.
module div_ctrl
   import div_pkg::*;
#(
   parameter int MW = 64,
   localparam int CW = $clog2(MW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          accept,
   output logic          do_setup,
   output logic          do_iter,
   output logic          finish,
   output logic          busy,
   output logic          done,
   output logic [CW-1:0] bit_idx
);
   div_phase_e    phase;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (start) phase <= PH_SETUP;
            end
            PH_SETUP: begin
               cnt   <= CW'(MW - 2);
               phase <= PH_ITER;
            end
            PH_ITER: begin
               if (cnt == '0) begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      busy     = (phase != PH_IDLE);
      accept   = start && (phase == PH_IDLE);
      do_setup = (phase == PH_SETUP);
      do_iter  = (phase == PH_ITER);
      finish   = do_iter && (cnt == '0);
      bit_idx  = cnt;
   end

   // R3: done lasts a single cycle
   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R3: once busy, stays busy until the completion edge raises done
   a_r3_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));
   // R3: done is only raised by a run that was in progress
   a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));
   // R2: start during a run does not restart the sequence
   a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (do_iter && start) |=> !do_setup);
endmodule

// File: rtl/iter_mant_divider.sv
module iter_mant_divider #(
   parameter int MW = 64,
   parameter int EW = 11
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 a_sign,
   input  logic signed [EW-1:0] a_exp,
   input  logic [MW-1:0]        a_mant,
   input  logic                 b_sign,
   input  logic signed [EW-1:0] b_exp,
   input  logic [MW-1:0]        b_mant,
   output logic                 busy,
   output logic                 done,
   output logic                 q_sign,
   output logic signed [EW:0]   q_exp,
   output logic [MW-1:0]        q_mant,
   output logic                 q_sticky
);
   localparam int CW = $clog2(MW);

   generate
      if (MW < 4) begin : g_bad_mw
         $error("iter_mant_divider: MW must be at least 4");
      end
      if (EW < 2) begin : g_bad_ew
         $error("iter_mant_divider: EW must be at least 2");
      end
   endgenerate

   logic          accept, do_setup, do_iter, finish;
   logic [CW-1:0] bit_idx;

   logic [MW-1:0]      xm, ym;
   logic [MW:0]        rem;
   logic [MW-1:0]      qw;
   logic signed [EW:0] ex_r;
   logic               sg_r;

   logic signed [EW:0] ediff_w;
   logic               sign_w;

   logic        s0_bit, s1_bit, it_bit;
   logic [MW:0] s0_rem, s1_rem, it_rem;

   div_ctrl #(.MW(MW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .accept(accept), .do_setup(do_setup), .do_iter(do_iter),
      .finish(finish), .busy(busy), .done(done), .bit_idx(bit_idx)
   );

   div_expo #(.EW(EW)) u_expo (
      .ea(a_exp), .eb(b_exp), .sa(a_sign), .sb(b_sign),
      .ediff(ediff_w), .sign(sign_w)
   );

   // Setup: X - Y decides normalization; otherwise 2X - Y (always >= 0).
   div_step #(.MW(MW)) u_setup_direct (
      .rem_in({1'b0, xm}), .divisor(ym), .pre_shift(1'b0),
      .q_bit(s0_bit), .rem_out(s0_rem)
   );
   div_step #(.MW(MW)) u_setup_doubled (
      .rem_in({1'b0, xm}), .divisor(ym), .pre_shift(1'b1),
      .q_bit(s1_bit), .rem_out(s1_rem)
   );
   // Iteration: shift, subtract, keep or restore.
   div_step #(.MW(MW)) u_iter (
      .rem_in(rem), .divisor(ym), .pre_shift(1'b1),
      .q_bit(it_bit), .rem_out(it_rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xm       <= '0;
         ym       <= '0;
         rem      <= '0;
         qw       <= '0;
         ex_r     <= '0;
         sg_r     <= 1'b0;
         q_sign   <= 1'b0;
         q_exp    <= '0;
         q_mant   <= '0;
         q_sticky <= 1'b0;
      end else begin
         if (accept) begin
            xm   <= a_mant;
            ym   <= b_mant;
            ex_r <= ediff_w;
            sg_r <= sign_w;
         end
         if (do_setup) begin
            rem        <= s0_bit ? s0_rem : s1_rem;
            qw         <= '0;
            qw[MW-1]   <= 1'b1;
            if (!s0_bit) ex_r <= ex_r - 1'b1;
         end
         if (do_iter) begin
            rem          <= it_rem;
            qw[bit_idx]  <= it_bit;
         end
         if (finish) begin
            q_mant   <= {qw[MW-1:1], it_bit};
            q_sticky <= |it_rem;
            q_exp    <= ex_r;
            q_sign   <= sg_r;
         end
      end
   end

   // R4: operands must arrive normalized
   a_r4_inputs_normal: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (a_mant[MW-1] && b_mant[MW-1]));
   // R4: doubling a dividend smaller than the divisor always clears it
   a_r4_doubled_fits: assert property (@(posedge clk) disable iff (!rst_n)
      (do_setup && !s0_bit) |-> s1_bit);
   // R7: partial remainder stays below the divisor through the loop
   a_r7_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      do_iter |-> (rem < {1'b0, ym}));
   // R4: quotient leaves normalized
   a_r4_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> q_mant[MW-1]);
   // R2: operands are not reloaded while busy
   a_r2_operands_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(ym) && $stable(xm)));
   // R8: results hold while idle
   a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(q_mant) && $stable(q_exp) &&
                             $stable(q_sticky) && $stable(q_sign)));
endmodule

// File: tb/sim_iter_mant_divider.sv
module sim_iter_mant_divider;
   localparam int MW = 64;
   localparam int EW = 11;
   localparam int CLK_PERIOD = 10;
   localparam int NRAND = 60;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic                 a_sign = 1'b0, b_sign = 1'b0;
   logic signed [EW-1:0] a_exp = '0, b_exp = '0;
   logic [MW-1:0]        a_mant = '0, b_mant = '0;
   logic                 busy, done, q_sign, q_sticky;
   logic signed [EW:0]   q_exp;
   logic [MW-1:0]        q_mant;

   int checks = 0;
   int errors = 0;

   iter_mant_divider #(.MW(MW), .EW(EW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
      .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
      .busy(busy), .done(done), .q_sign(q_sign), .q_exp(q_exp),
      .q_mant(q_mant), .q_sticky(q_sticky)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [MW-1:0] rand_mant();
      logic [MW-1:0] m;
      m = {$urandom, $urandom};
      m[MW-1] = 1'b1;
      return m;
   endfunction

   task automatic run_div(input logic sa, input logic signed [EW-1:0] ea,
                          input logic [MW-1:0] ma,
                          input logic sb, input logic signed [EW-1:0] eb,
                          input logic [MW-1:0] mb,
                          input bit poke, input bit hold);
      logic [2*MW:0] num, quo, rmd;
      int e_exp, lat;
      bit busy_ok;
      logic [MW-1:0] m_snap;
      num = (ma >= mb) ? ({{(MW+1){1'b0}}, ma} << (MW-1))
                       : ({{(MW+1){1'b0}}, ma} << MW);
      quo = num / {{(MW+1){1'b0}}, mb};
      rmd = num % {{(MW+1){1'b0}}, mb};
      e_exp = int'(ea) - int'(eb) - ((ma < mb) ? 1 : 0);

      @(negedge clk);
      a_sign = sa; a_exp = ea; a_mant = ma;
      b_sign = sb; b_exp = eb; b_mant = mb;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      busy_ok = 1'b1;
      for (int j = 1; j <= MW + 4; j++) begin
         if (poke && j == 2) begin
            start = 1'b1; a_mant = ~ma; b_mant = {1'b1, ~mb[MW-2:0]};
            a_exp = eb; a_sign = ~sa;
         end
         if (poke && j == 3) start = 1'b0;
         @(posedge clk);
         @(negedge clk);
         if (done) begin lat = j; break; end
         if (!busy) busy_ok = 1'b0;
      end
      // R3 latency and busy window
      check(lat == MW, "R3", "done latency", 128'(lat), 128'(MW));
      check(busy_ok && !busy, "R3", "busy window", 128'(busy), 128'(0));
      // R4 quotient (poked runs also cover R2)
      check(q_mant == quo[MW-1:0], poke ? "R2/R4" : "R4", "q_mant",
            128'(q_mant), 128'(quo[MW-1:0]));
      // R5 exponent
      check(int'(q_exp) == e_exp, "R5", "q_exp",
            128'(q_exp), 128'(e_exp));
      // R6 sign
      check(q_sign == (sa ^ sb), "R6", "q_sign",
            128'(q_sign), 128'(sa ^ sb));
      // R7 sticky
      check(q_sticky == (rmd != 0), "R7", "q_sticky",
            128'(q_sticky), 128'(rmd != 0));
      if (hold) begin
         m_snap = q_mant;
         repeat (4) @(negedge clk);
         // R8 results held while idle
         check(q_mant == m_snap && !done, "R8", "hold after done",
               128'(q_mant), 128'(m_snap));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [MW-1:0] one, maxm, m;
      void'($urandom(32'd20240611));
      one  = {1'b1, {(MW-1){1'b0}}};
      maxm = '1;

      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy && !done, "R1", "busy/done in reset",
            128'({busy, done}), 128'(0));
      check(q_mant == '0 && q_exp == '0 && !q_sign && !q_sticky, "R1",
            "results in reset", 128'(q_mant), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done, "R1", "idle after reset",
            128'({busy, done}), 128'(0));

      // R9 equal mantissas
      run_div(1'b0, 11'sd5, one, 1'b0, 11'sd3, one, 1'b0, 1'b1);
      check(q_mant == one && !q_sticky, "R9", "1.0/1.0", 128'(q_mant), 128'(one));
      m = rand_mant();
      run_div(1'b1, -11'sd7, m, 1'b0, 11'sd2, m, 1'b0, 1'b0);
      check(q_mant == one && int'(q_exp) == -9, "R9", "x/x",
            128'(q_exp), 128'(-9));
      // one-ulp neighbours of equality
      m = rand_mant(); m[0] = 1'b0;
      run_div(1'b0, 11'sd0, m + 1'b1, 1'b1, 11'sd0, m, 1'b0, 1'b0);
      run_div(1'b1, 11'sd0, m, 1'b1, 11'sd0, m + 1'b1, 1'b0, 1'b0);
      // largest / smallest mantissa and the reverse
      run_div(1'b0, 11'sd1, maxm, 1'b0, 11'sd0, one, 1'b0, 1'b1);
      run_div(1'b0, 11'sd0, one, 1'b1, 11'sd1, maxm, 1'b0, 1'b0);
      // R5 extreme exponents, both normalization branches
      run_div(1'b0, -11'sd1024, one, 1'b0, 11'sd1023, maxm, 1'b0, 1'b0);
      check(int'(q_exp) == -2048, "R5", "most negative exponent",
            128'(q_exp), 128'(-2048));
      run_div(1'b1, 11'sd1023, maxm, 1'b0, -11'sd1024, one, 1'b0, 1'b0);
      check(int'(q_exp) == 2047, "R5", "most positive exponent",
            128'(q_exp), 128'(2047));
      // R2 start while busy, directed
      run_div(1'b0, 11'sd3, rand_mant(), 1'b1, 11'sd4, rand_mant(), 1'b1, 1'b1);

      for (int k = 0; k < NRAND; k++) begin
         run_div(1'($urandom), EW'($urandom), rand_mant(),
                 1'($urandom), EW'($urandom), rand_mant(),
                 (k % 7) == 3, (k % 5) == 1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule